// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller sits next to a small processor core and chooses which interrupt the core takes next. It has a parameterised number of request sources. Each source has one sticky pending bit and its own enable, and each can be set to capture rising edges or to follow a held level. A single global enable gates every maskable source. The controller clears that enable when it dispatches an interrupt, and the core's return strobe sets it again. After any re-enable, the core must retire one instruction before the next maskable dispatch can happen.

Normal-priority sources are arbitrated by fixed index order or by a rotating search, chosen by an input. One source can be promoted to high priority, and it may then preempt a running normal handler. A separate non-maskable line bypasses the global enable completely. The core sees a take request together with a vector number, and it accepts by raising an acknowledge in the same cycle. A small level stack records which handler levels are active, so that each return unwinds exactly one level.

Top module: `ivc_top`

## Requirements
- R1: An edge-type source (`edge_sel_i` bit = 1) sets its pending bit on a rising edge of its request line, whatever the global enable is. The bit is visible on `pend_o` one cycle after the edge is sampled.
- R2: Each source holds only one pending bit. Further rises on that source while the bit is set are lost, so one dispatch services all of them.
- R3: A maskable source is offered (`take_o` = 1) only when all of the following hold: its pending bit is set, its `src_en_i` bit is set, and either the global enable is set at thread level or the source is the high-priority source preempting a normal handler.
- R4: Accepting a maskable interrupt (`take_o` and `ack_i` in one cycle) clears the global enable from the next cycle on. A return that leaves every maskable level sets it again.
- R5: After the global enable is set by `gie_set_i` or by a return, no maskable interrupt is offered until a `retire_i` pulse has arrived in a later cycle. The offer can appear in the cycle after that pulse.
- R6: While `gie_clr_i` is high, no maskable interrupt is offered in that cycle, and the global enable reads 0 from the next cycle on.
- R7: In static mode (`rr_mode_i` = 0), the lowest-indexed eligible normal source wins.
- R8: In rotating mode (`rr_mode_i` = 1), the search starts at the index after the last accepted normal source and wraps from N_SRC-1 to 0. After reset the search starts at index 0.
- R9: When `hp_en_i` is 1, source `hp_idx_i` is high priority. It beats normal sources and may preempt a normal handler. Normal requests wait until every handler level has returned.
- R10: A rising edge on `nmi_i` pends the non-maskable request. It is offered with vector N_SRC whatever the global enable is, but never while a non-maskable handler is active. Its return leaves the global enable unchanged.
- R11: A level-type source (`edge_sel_i` bit = 0) sets its pending bit in every cycle its line is high, so it re-pends straight after acceptance while the line stays high. An accepted edge-type source's bit is cleared.
- R12: `act_lvl_o` gives the active level: 0 thread, 1 normal, 2 high, 3 non-maskable. Each acceptance raises it to the taken level, and each `reti_i` returns it to the level below.
- R13: After reset, `take_o`, `gie_o`, `act_lvl_o` and `pend_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Raw request lines |
| edge_sel_i | input | N_SRC | 1 = edge-captured source, 0 = level source |
| src_en_i | input | N_SRC | Per-source enable |
| rr_mode_i | input | 1 | 1 = rotating arbitration of normal sources |
| hp_en_i | input | 1 | Enables promotion of one source to high priority |
| hp_idx_i | input | $clog2(N_SRC) | Index of the promoted source |
| nmi_i | input | 1 | Non-maskable request line (edge) |
| gie_set_i | input | 1 | Explicit global enable strobe |
| gie_clr_i | input | 1 | Explicit global disable strobe |
| retire_i | input | 1 | Instruction-retired pulse from the core |
| ack_i | input | 1 | Core accepts the offered interrupt this cycle |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | Interrupt offered to the core |
| vec_o | output | $clog2(N_SRC+1) | Offered vector; N_SRC means non-maskable |
| act_lvl_o | output | 2 | Active handler level |
| gie_o | output | 1 | Global interrupt enable |
| pend_o | output | N_SRC | Pending bits |

## Verification
Two sets of events can fall in the same cycle. A disable can arrive while an offer is standing, and an enable or return can come close to a `retire_i` pulse. The bench makes the first happen by raising `gie_clr_i` in the very cycle a pending source is being offered, and it checks that `take_o` drops at once while the pending bit survives. For the second, `retire_i` is placed in the cycle right after `gie_set_i` or `reti_i`, and the bench checks that the offer appears only one cycle after that pulse. In both cases a behavioural model is compared with the outputs on every clock.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    // Active handler level, ordered by urgency
    typedef enum logic [1:0] {
        LVL_THREAD = 2'd0,
        LVL_NORM   = 2'd1,
        LVL_HIGH   = 2'd2,
        LVL_NMI    = 2'd3
    } ivc_lvl_e;

endpackage

// File: rtl/ivc_pend.sv
module ivc_pend #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] edge_sel_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_SRC; i++) begin
            logic hit;
            hit = edge_sel_i[i] ? (req_i[i] & ~st_q.prev[i]) : req_i[i];
            // a fresh capture outranks the clear of the accepted source
            st_d.pend[i] = (st_q.pend[i] & ~clr_i[i]) | hit;
            st_d.prev[i] = req_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/ivc_arb.sv
module ivc_arb #(
    parameter int N_SRC = 8,
    parameter bit RR_EN = 1'b1,
    localparam int IW = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] cand_i,
    input  logic             rr_i,
    input  logic [IW-1:0]    last_i,
    output logic             any_o,
    output logic [IW-1:0]    idx_o
);

    logic [IW-1:0] st_idx;
    logic [IW-1:0] rot_idx;

    // fixed order: lowest index wins
    always_comb begin
        st_idx = '0;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (cand_i[k]) st_idx = IW'(k);
        end
    end

    generate
        if (RR_EN) begin : g_rot
            always_comb begin
                logic found;
                found   = 1'b0;
                rot_idx = '0;
                for (int k = 0; k < N_SRC; k++) begin
                    int j;
                    j = (int'(last_i) + 1 + k) % N_SRC;
                    if (!found && cand_i[j]) begin
                        found   = 1'b1;
                        rot_idx = IW'(j);
                    end
                end
            end
            assign idx_o = rr_i ? rot_idx : st_idx;
        end else begin : g_fixed
            assign rot_idx = st_idx;
            assign idx_o   = st_idx;
        end
    endgenerate

    assign any_o = |cand_i;

endmodule

// File: rtl/ivc_stack.sv
module ivc_stack
    import ivc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  ivc_lvl_e push_lvl_i,
    input  logic     pop_i,
    output ivc_lvl_e lvl_o,
    output logic     unwind_o
);

    // one bit per handler level: [0] normal, [1] high, [2] non-maskable
    logic [2:0] act_d, act_q;

    always_comb begin
        act_d    = act_q;
        unwind_o = 1'b0;
        if (act_q[2])      lvl_o = LVL_NMI;
        else if (act_q[1]) lvl_o = LVL_HIGH;
        else if (act_q[0]) lvl_o = LVL_NORM;
        else               lvl_o = LVL_THREAD;

        if (pop_i) begin
            if (act_q[2])      act_d[2] = 1'b0;
            else if (act_q[1]) act_d[1] = 1'b0;
            else               act_d[0] = 1'b0;
            unwind_o = (act_q == 3'b001) || (act_q == 3'b010);
        end else if (push_i) begin
            case (push_lvl_i)
                LVL_NORM: act_d[0] = 1'b1;
                LVL_HIGH: act_d[1] = 1'b1;
                LVL_NMI:  act_d[2] = 1'b1;
                default:  act_d    = act_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter bit RR_EN = 1'b1,
    localparam int IW = $clog2(N_SRC),
    localparam int VW = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] edge_sel_i,
    input  logic [N_SRC-1:0] src_en_i,
    input  logic             rr_mode_i,
    input  logic             hp_en_i,
    input  logic [IW-1:0]    hp_idx_i,
    input  logic             nmi_i,
    input  logic             gie_set_i,
    input  logic             gie_clr_i,
    input  logic             retire_i,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic             take_o,
    output logic [VW-1:0]    vec_o,
    output logic [1:0]       act_lvl_o,
    output logic             gie_o,
    output logic [N_SRC-1:0] pend_o
);

    localparam logic [VW-1:0] NMI_VEC = VW'(N_SRC);

    typedef struct packed {
        logic          gie;
        logic          arm;       // waiting for one retired instruction
        logic [IW-1:0] last;      // last accepted normal source
        logic          nmi_prev;
        logic          nmi_pend;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic [N_SRC-1:0] pend, cand, hp_mask, clr_vec;
    logic             arb_any, unwind, accept;
    logic             nmi_ok, hp_ok, norm_ok, open_thread;
    logic [IW-1:0]    arb_idx;
    ivc_lvl_e         lvl, push_lvl;

    ivc_pend #(.N_SRC(N_SRC)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .edge_sel_i (edge_sel_i),
        .clr_i      (clr_vec),
        .pend_o     (pend)
    );

    ivc_arb #(.N_SRC(N_SRC), .RR_EN(RR_EN)) u_arb (
        .cand_i (cand),
        .rr_i   (rr_mode_i),
        .last_i (cur_q.last),
        .any_o  (arb_any),
        .idx_o  (arb_idx)
    );

    ivc_stack u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (accept),
        .push_lvl_i (push_lvl),
        .pop_i      (reti_i),
        .lvl_o      (lvl),
        .unwind_o   (unwind)
    );

    always_comb begin
        nxt_d = cur_q;

        hp_mask = hp_en_i ? (N_SRC'(1) << hp_idx_i) : '0;
        cand    = pend & src_en_i & ~hp_mask;

        open_thread = cur_q.gie & ~cur_q.arm & ~gie_clr_i & ~reti_i
                    & (lvl == LVL_THREAD);
        nmi_ok  = cur_q.nmi_pend & ~reti_i & (lvl != LVL_NMI);
        hp_ok   = hp_en_i & pend[hp_idx_i] & src_en_i[hp_idx_i] & ~gie_clr_i & ~reti_i
                & (open_thread | (lvl == LVL_NORM));
        norm_ok = open_thread & arb_any;

        take_o = nmi_ok | hp_ok | norm_ok;
        if (nmi_ok)     vec_o = NMI_VEC;
        else if (hp_ok) vec_o = VW'(hp_idx_i);
        else            vec_o = VW'(arb_idx);

        accept = take_o & ack_i;
        if (nmi_ok)     push_lvl = LVL_NMI;
        else if (hp_ok) push_lvl = LVL_HIGH;
        else            push_lvl = LVL_NORM;

        clr_vec = '0;
        if (accept && !nmi_ok) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (vec_o == VW'(i)) clr_vec[i] = 1'b1;
            end
        end

        // global enable and retire gate; disables are applied last
        nxt_d.arm = cur_q.arm & ~retire_i;
        if (unwind) begin
            nxt_d.gie = 1'b1;
            nxt_d.arm = 1'b1;
        end
        if (gie_set_i) begin
            nxt_d.gie = 1'b1;
            nxt_d.arm = 1'b1;
        end
        if (accept && !nmi_ok) begin
            nxt_d.gie = 1'b0;
            if (!hp_ok) nxt_d.last = arb_idx;
        end
        if (gie_clr_i) nxt_d.gie = 1'b0;

        nxt_d.nmi_prev = nmi_i;
        nxt_d.nmi_pend = (cur_q.nmi_pend & ~(accept & nmi_ok)) | (nmi_i & ~cur_q.nmi_prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.last     <= IW'(N_SRC - 1);
        end else begin
            cur_q          <= nxt_d;
        end
    end

    assign act_lvl_o = lvl;
    assign gie_o     = cur_q.gie;
    assign pend_o    = pend;

endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
    parameter int N_SRC = 8,
    localparam int IW = $clog2(N_SRC),
    localparam int VW = $clog2(N_SRC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gie_clr_i,
    input logic             ack_i,
    input logic [N_SRC-1:0] src_en_i,
    input logic             take_o,
    input logic [VW-1:0]    vec_o,
    input logic [1:0]       act_lvl_o,
    input logic             gie_o,
    input logic [N_SRC-1:0] pend_o
);

    localparam logic [VW-1:0] NMI_VEC = VW'(N_SRC);

    // R2: a pending bit only falls on an accepted dispatch
    a_r2_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_o && ack_i) |=> ((~pend_o & $past(pend_o)) == '0));

    // R3: a maskable offer at thread level needs enable, pending and source enable
    a_r3_offer_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o != NMI_VEC && act_lvl_o == 2'd0)
            |-> (gie_o && pend_o[vec_o[IW-1:0]] && src_en_i[vec_o[IW-1:0]]));

    // R4: a maskable acceptance drops the global enable
    a_r4_entry_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_i && vec_o != NMI_VEC) |=> !gie_o);

    // R5: no maskable offer in the cycle the enable first reads 1
    a_r5_retire_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie_o) |-> (!take_o || vec_o == NMI_VEC));

    // R6: a disable strobe suppresses maskable offers in its own cycle
    a_r6_disable_now: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr_i |-> (!take_o || vec_o == NMI_VEC));

    // R10: the non-maskable vector never nests into itself
    a_r10_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vec_o == NMI_VEC) |-> act_lvl_o != 2'd3);

    // R12: every acceptance raises the active level
    a_r12_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ack_i) |=> act_lvl_o > $past(act_lvl_o));

endmodule

bind ivc_top ivc_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gie_clr_i (gie_clr_i),
    .ack_i     (ack_i),
    .src_en_i  (src_en_i),
    .take_o    (take_o),
    .vec_o     (vec_o),
    .act_lvl_o (act_lvl_o),
    .gie_o     (gie_o),
    .pend_o    (pend_o)
);

// File: tb/sim_ivc_top.sv
`timescale 1ns/1ps
module sim_ivc_top;

    localparam int N  = 8;
    localparam int IW = $clog2(N);
    localparam int VW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req = '0, edge_sel = 8'h7F, src_en = 8'hFF;
    logic rr = 0, hp_en = 0, nmi = 0, gie_set = 0, gie_clr = 0, retire = 0, reti = 0, ack_en = 0;
    logic [IW-1:0] hp_idx = IW'(4);
    logic take, gie;
    logic [VW-1:0] vec;
    logic [1:0] lvl;
    logic [N-1:0] pend;
    wire ack = ack_en & take;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    ivc_top #(.N_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .edge_sel_i(edge_sel), .src_en_i(src_en),
        .rr_mode_i(rr), .hp_en_i(hp_en), .hp_idx_i(hp_idx), .nmi_i(nmi),
        .gie_set_i(gie_set), .gie_clr_i(gie_clr), .retire_i(retire), .ack_i(ack),
        .reti_i(reti), .take_o(take), .vec_o(vec), .act_lvl_o(lvl), .gie_o(gie), .pend_o(pend)
    );

    task automatic chk_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [N-1:0] m_pend, m_prev;
    bit m_gie, m_arm, m_nmip, m_nmiprev;
    int m_last;
    int m_stack[$];

    function automatic int m_lvl();
        return (m_stack.size() == 0) ? 0 : m_stack[$];
    endfunction

    task automatic m_eval(output bit t, output int v);
        int l;
        bit hp_ok;
        l = m_lvl();
        t = 0;
        v = 0;
        if (!reti) begin
            hp_ok = hp_en && m_pend[hp_idx] && src_en[hp_idx] && !gie_clr
                 && ((l == 0 && m_gie && !m_arm) || l == 1);
            if (m_nmip && l != 3) begin
                t = 1; v = N;
            end else if (hp_ok) begin
                t = 1; v = int'(hp_idx);
            end else if (l == 0 && m_gie && !m_arm && !gie_clr) begin
                for (int k = 0; k < N; k++) begin
                    int j;
                    j = rr ? (m_last + 1 + k) % N : k;
                    if (!t && m_pend[j] && src_en[j] && !(hp_en && j == int'(hp_idx))) begin
                        t = 1; v = j;
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_prev = '0; m_gie = 0; m_arm = 0;
            m_nmip = 0; m_nmiprev = 0; m_last = N - 1;
            m_stack.delete();
        end else begin
            bit t, acc, ng, na;
            int v;
            m_eval(t, v);
            acc = t && ack_en;
            ng = m_gie;
            na = m_arm && !retire;
            if (reti && m_stack.size() > 0) begin
                int top;
                top = m_stack.pop_back();
                if (top != 3 && m_stack.size() == 0) begin ng = 1; na = 1; end
            end
            if (gie_set) begin ng = 1; na = 1; end
            if (acc) begin
                if (v == N) m_stack.push_back(3);
                else begin
                    ng = 0;
                    if (hp_en && v == int'(hp_idx)) m_stack.push_back(2);
                    else begin m_stack.push_back(1); m_last = v; end
                end
            end
            if (gie_clr) ng = 0;
            m_gie = ng;
            m_arm = na;
            for (int i = 0; i < N; i++) begin
                bit s;
                s = edge_sel[i] ? (req[i] && !m_prev[i]) : req[i];
                m_pend[i] = (m_pend[i] && !(acc && v == i)) || s;
                m_prev[i] = req[i];
            end
            m_nmip = (m_nmip && !(acc && v == N)) || (nmi && !m_nmiprev);
            m_nmiprev = nmi;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit t;
            int v;
            m_eval(t, v);
            chk_eq("R3 model take", int'(take), int'(t));
            if (t) chk_eq("R7 model vector", int'(vec), v);
            chk_eq("R4 model gie", int'(gie), int'(m_gie));
            chk_eq("R12 model level", int'(lvl), m_lvl());
            chk_eq("R1 model pending", int'(pend), int'(m_pend));
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic nxt();
        @(posedge clk);
        #2;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic enable_gie();
        gie_set = 1; nxt(); gie_set = 0; retire = 1;
        at_neg();
        chk_eq("R5 enable seen", int'(gie), 1);
        chk_eq("R5 no offer before retire", int'(take), 0);
        nxt(); retire = 0;
    endtask

    task automatic serve(int v, int l, string tag);
        at_neg();
        chk_eq({tag, " offer"}, int'(take), 1);
        chk_eq({tag, " vector"}, int'(vec), v);
        ack_en = 1; nxt(); ack_en = 0;
        at_neg();
        chk_eq("R12 entered level", int'(lvl), l);
        chk_eq("R4 gie cleared on entry", int'(gie), 0);
        reti = 1; nxt(); reti = 0;
        at_neg();
        chk_eq("R4 gie restored on return", int'(gie), 1);
        chk_eq("R12 back at thread", int'(lvl), 0);
        chk_eq("R5 no offer after return", int'(take), 0);
        retire = 1; nxt(); retire = 0;
    endtask

    task automatic pulse_req(logic [N-1:0] m);
        req = m; nxt(); req = '0;
    endtask

    initial begin
        repeat (3) nxt();
        rst_n = 1;
        at_neg();
        chk_eq("R13 reset take", int'(take), 0);
        chk_eq("R13 reset gie", int'(gie), 0);
        chk_eq("R13 reset level", int'(lvl), 0);
        chk_eq("R13 reset pending", int'(pend), 0);

        // R1 / R2 / R3: capture with enable off, repeats are lost
        nxt();
        pulse_req(8'h08);
        at_neg();
        chk_eq("R1 edge captured", int'(pend[3]), 1);
        chk_eq("R3 held with gie off", int'(take), 0);
        for (int r = 0; r < 2; r++) begin
            nxt(); pulse_req(8'h08);
        end
        nxt();
        enable_gie();
        serve(3, 1, "R5");
        at_neg();
        chk_eq("R2 repeats lost", int'(take), 0);
        chk_eq("R2 pending empty", int'(pend), 0);

        // R7: static order
        nxt();
        gie_clr = 1; nxt(); gie_clr = 0;
        pulse_req(8'h64);
        nxt();
        enable_gie();
        serve(2, 1, "R7");
        serve(5, 1, "R7");
        serve(6, 1, "R7");

        // R6: disable in the same cycle as a standing offer
        pulse_req(8'h02);
        at_neg();
        chk_eq("R6 offer before disable", int'(take), 1);
        nxt(); gie_clr = 1;
        at_neg();
        chk_eq("R6 blocked same cycle", int'(take), 0);
        nxt(); gie_clr = 0;
        at_neg();
        chk_eq("R6 gie now off", int'(gie), 0);
        chk_eq("R6 request kept", int'(pend[1]), 1);

        // R8: rotation from last serviced index 6
        nxt();
        rr = 1;
        pulse_req(8'h90);
        nxt();
        enable_gie();
        serve(7, 1, "R8");
        serve(1, 1, "R8 wrap");
        serve(4, 1, "R8");
        rr = 0;

        // R9: high priority preempts a normal handler
        hp_en = 1;
        pulse_req(8'h02);
        at_neg();
        chk_eq("R9 normal offered", int'(vec), 1);
        ack_en = 1; nxt(); ack_en = 0;
        pulse_req(8'h11);
        at_neg();
        chk_eq("R9 preempt offer", int'(take), 1);
        chk_eq("R9 preempt vector", int'(vec), 4);
        ack_en = 1; nxt(); ack_en = 0;
        at_neg();
        chk_eq("R12 high level", int'(lvl), 2);
        chk_eq("R9 normal waits", int'(take), 0);
        reti = 1; nxt(); reti = 0;
        at_neg();
        chk_eq("R12 back to normal", int'(lvl), 1);
        chk_eq("R9 equal level waits", int'(take), 0);
        chk_eq("R4 gie stays off", int'(gie), 0);
        reti = 1; nxt(); reti = 0;
        retire = 1; nxt(); retire = 0;
        serve(0, 1, "R9");
        gie_clr = 1; nxt(); gie_clr = 0;
        pulse_req(8'h14);
        nxt();
        enable_gie();
        serve(4, 2, "R9 beats lower index");
        serve(2, 1, "R9");
        hp_en = 0;

        // R10: non-maskable
        gie_clr = 1; nxt(); gie_clr = 0;
        nmi = 1; nxt(); nmi = 0;
        at_neg();
        chk_eq("R10 offer with gie off", int'(take), 1);
        chk_eq("R10 vector", int'(vec), N);
        ack_en = 1; nxt(); ack_en = 0;
        nmi = 1; nxt(); nmi = 0;
        at_neg();
        chk_eq("R12 nmi level", int'(lvl), 3);
        chk_eq("R10 no nesting", int'(take), 0);
        reti = 1; nxt(); reti = 0;
        at_neg();
        chk_eq("R10 gie unchanged", int'(gie), 0);
        chk_eq("R10 second offer", int'(vec), N);
        ack_en = 1; nxt(); ack_en = 0;
        reti = 1; nxt(); reti = 0;
        at_neg();
        chk_eq("R10 drained", int'(take), 0);

        // R11: level source re-pends while held
        nxt();
        enable_gie();
        req = 8'h80; nxt();
        at_neg();
        chk_eq("R11 level offer", int'(vec), 7);
        ack_en = 1; nxt(); ack_en = 0;
        at_neg();
        chk_eq("R11 re-pended", int'(pend[7]), 1);
        nxt(); req = '0;
        reti = 1; nxt(); reti = 0;
        retire = 1; nxt(); retire = 0;
        serve(7, 1, "R11");
        at_neg();
        chk_eq("R11 cleared once low", int'(pend[7]), 0);

        nxt();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule